// File: doc/BRIEF.md
# Process-ID Address Relocation and Alignment Checker

This block sits on the load/store address path between the core and memory. Each address passes through it combinationally. Two settings from the system-control register bank drive it. The first is a process-ID register. Its upper seven bits form a relocation base. When that base is nonzero and the incoming address lies in the lowest 32 MB (its top seven bits are all zero), the base is ORed into the address. This lets every process use the same low virtual window while landing in its own slot. Addresses that already carry upper bits go through unchanged.

The second setting is a control register. When its alignment-check bit is set, any access whose two low address bits are not both zero raises a fault flag in the same cycle. On the following clock edge the block presents a fault status value and the faulting address, each with a one-cycle write strobe, for capture by the fault status and fault address registers. The feature-enable input turns the whole function off. With it low, addresses pass untouched and no fault is raised.

Top module: `pid_reloc_check`

## Requirements
- R1: With `en` low, `addr_out` equals `addr_in`, `fault` is 0, and neither strobe rises on the next edge, whatever the other inputs hold.
- R2: The relocation base is `pid_reg` with only bits 31:25 kept. With `en` high, a nonzero base and `addr_in[31:25]` all zero, `addr_out` equals `addr_in | base`.
- R3: When `addr_in[31:25]` is not all zero, `addr_out` equals `addr_in` regardless of the process ID.
- R4: When `pid_reg[31:25]` is zero, `addr_out` equals `addr_in`. Bits 24:0 of `pid_reg` never affect any output.
- R5: With `en` high, `ctrl_reg[1]` set and `addr_in[1:0]` nonzero, `fault` is 1 in the same cycle.
- R6: `fault` is 0 when `ctrl_reg[1]` is clear or `addr_in[1:0]` is zero. Control bits other than bit 1 have no effect.
- R7: In the cycle after a faulting cycle, `fsr_we` and `far_we` are both 1 and `far_val` holds that cycle's `addr_out`. This is the relocated address. In a cycle after a non-faulting cycle, both strobes are 0.
- R8: On a fault strobe, `fsr_val[7:0]` is the alignment code 0x01, `fsr_val[8]` is the `is_store` value of the faulting access, and `fsr_val[10:9]` are 0.
- R9: While reset is asserted and after its release, before any fault, the strobes are 0 and `fsr_val` and `far_val` are 0.
- R10: `addr_out` and `fault` follow the inputs in the same cycle, with no register on that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Feature enable for relocation and checking |
| addr_in | input | 32 | Access address from the core |
| is_store | input | 1 | 1 for a store, 0 for a load |
| pid_reg | input | 32 | Process-ID register value |
| ctrl_reg | input | 32 | Control register value; bit 1 enables alignment checking |
| addr_out | output | 32 | Possibly relocated address to memory |
| fault | output | 1 | Alignment fault for the current access |
| fsr_val | output | 11 | Fault status value to capture |
| fsr_we | output | 1 | Write strobe for the fault status register |
| far_val | output | 32 | Faulting address to capture |
| far_we | output | 1 | Write strobe for the fault address register |

## Verification
Relocation and an alignment fault can occur on the same access. This happens when the address sits in the low window, the process ID is nonzero, checking is on and the low bits are misaligned. The bench forces this case directly, and it also comes up from random stimulus biased toward low-window addresses. It is judged on the next cycle. `far_val` must equal the relocated address, not the raw one. In the same cycle `addr_out` must already show the OR of the base.

// File: rtl/pid_reloc_check.sv
module pid_reloc_check #(
  parameter int ADDR_W     = 32,
  parameter int PID_BITS   = 7,
  parameter int ALIGN_BIT  = 1,
  parameter int FSR_W      = 11,
  parameter int CODE_W     = 8,
  parameter logic [CODE_W-1:0] ALIGN_CODE = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              is_store,
  input  logic [ADDR_W-1:0] pid_reg,
  input  logic [ADDR_W-1:0] ctrl_reg,
  output logic [ADDR_W-1:0] addr_out,
  output logic              fault,
  output logic [FSR_W-1:0]  fsr_val,
  output logic              fsr_we,
  output logic [ADDR_W-1:0] far_val,
  output logic              far_we
);

  localparam int LOW_W = ADDR_W - PID_BITS;
  localparam logic [ADDR_W-1:0] TOP_MASK = {{PID_BITS{1'b1}}, {LOW_W{1'b0}}};

  logic [ADDR_W-1:0] base;
  logic              in_low_win;
  logic              do_reloc;
  logic              misalign;
  logic [FSR_W-1:0]  status_nxt;

  assign base       = pid_reg & TOP_MASK;
  assign in_low_win = (addr_in & TOP_MASK) == '0;
  assign do_reloc   = en && in_low_win && (base != '0);
  assign addr_out   = do_reloc ? (addr_in | base) : addr_in;

  assign misalign   = addr_in[1:0] != 2'b00;
  assign fault      = en && ctrl_reg[ALIGN_BIT] && misalign;

  always_comb begin
    status_nxt = '0;
    status_nxt[CODE_W-1:0] = ALIGN_CODE;
    status_nxt[CODE_W]     = is_store;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_we  <= 1'b0;
      far_we  <= 1'b0;
      fsr_val <= '0;
      far_val <= '0;
    end else begin
      fsr_we <= fault;
      far_we <= fault;
      if (fault) begin
        fsr_val <= status_nxt;
        far_val <= addr_out;
      end
    end
  end

  a_r1_off_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (addr_out == addr_in) && !fault);

  a_r3_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    addr_out[LOW_W-1:0] == addr_in[LOW_W-1:0]);

  a_r7_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fsr_we && far_we && (far_val == $past(addr_out)));

  a_r7_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |=> !fsr_we && !far_we);

  a_r8_store_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fsr_val[CODE_W] == $past(is_store));

  a_r5_fault_needs_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (addr_in[1:0] != 2'b00) && ctrl_reg[ALIGN_BIT]);

endmodule

// File: tb/pid_reloc_check_tb.sv
module pid_reloc_check_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] addr_in = '0;
  logic        is_store = 1'b0;
  logic [31:0] pid_reg = '0;
  logic [31:0] ctrl_reg = '0;
  logic [31:0] addr_out;
  logic        fault;
  logic [10:0] fsr_val;
  logic        fsr_we;
  logic [31:0] far_val;
  logic        far_we;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pid_reloc_check u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .addr_in(addr_in), .is_store(is_store),
    .pid_reg(pid_reg), .ctrl_reg(ctrl_reg), .addr_out(addr_out), .fault(fault),
    .fsr_val(fsr_val), .fsr_we(fsr_we), .far_val(far_val), .far_we(far_we)
  );

  function automatic logic [31:0] exp_addr(logic e, logic [31:0] a, logic [31:0] p);
    logic [31:0] b = p & 32'hFE00_0000;
    if (e && b != 0 && a[31:25] == 7'd0) return a | b;
    return a;
  endfunction

  function automatic logic exp_fault(logic e, logic [31:0] a, logic [31:0] c);
    return e && c[1] && (a[1:0] != 2'b00);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(string req, logic e, logic [31:0] a, logic st,
                       logic [31:0] p, logic [31:0] c);
    logic [31:0] ea;
    logic ef;
    @(negedge clk);
    en = e; addr_in = a; is_store = st; pid_reg = p; ctrl_reg = c;
    #1;
    ea = exp_addr(e, a, p);
    ef = exp_fault(e, a, c);
    chk({req, " addr_out (R10)"}, addr_out, ea);
    chk({req, " fault (R10)"}, {31'd0, fault}, {31'd0, ef});
    @(posedge clk); #1;
    chk({req, " fsr_we R7"}, {31'd0, fsr_we}, {31'd0, ef});
    chk({req, " far_we R7"}, {31'd0, far_we}, {31'd0, ef});
    if (ef) begin
      chk({req, " far_val R7"}, far_val, ea);
      chk({req, " fsr_val R8"}, {21'd0, fsr_val}, {21'd0, 2'b00, st, 8'h01});
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 fsr_we reset", {31'd0, fsr_we}, 32'd0);
    chk("R9 far_we reset", {31'd0, far_we}, 32'd0);
    chk("R9 fsr_val reset", {21'd0, fsr_val}, 32'd0);
    chk("R9 far_val reset", far_val, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R9 after release", {30'd0, fsr_we, far_we}, 32'd0);

    apply("R1 off misaligned", 1'b0, 32'h0000_1003, 1'b1, 32'hFE00_0000, 32'hFFFF_FFFF);
    apply("R2 relocate", 1'b1, 32'h0012_3450, 1'b0, 32'h0600_0000, 32'h0);
    apply("R2 max pid", 1'b1, 32'h01FF_FFFC, 1'b0, 32'hFFFF_FFFF, 32'h2);
    apply("R3 high addr", 1'b1, 32'h0200_0000, 1'b0, 32'hFE00_0000, 32'h0);
    apply("R3 top bit", 1'b1, 32'h8000_0010, 1'b0, 32'h0A00_0000, 32'h0);
    apply("R4 low pid bits", 1'b1, 32'h0000_0040, 1'b0, 32'h01FF_FFFF, 32'h0);
    apply("R5 fault load", 1'b1, 32'h8000_0001, 1'b0, 32'h0, 32'h2);
    apply("R5 fault store", 1'b1, 32'h8000_0002, 1'b1, 32'h0, 32'h2);
    apply("R6 check off", 1'b1, 32'h0000_0003, 1'b1, 32'h0, 32'hFFFF_FFFD);
    apply("R6 aligned", 1'b1, 32'h0000_0100, 1'b1, 32'h0, 32'h2);
    apply("R7 reloc+fault", 1'b1, 32'h0000_2001, 1'b1, 32'h1400_0000, 32'h2);
    apply("R7 back to back", 1'b1, 32'h0000_2003, 1'b0, 32'h1400_0000, 32'h2);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a = $urandom;
      logic [31:0] p = $urandom;
      logic [31:0] c = $urandom;
      if ($urandom_range(0, 1) == 1) a[31:25] = 7'd0;
      if ($urandom_range(0, 3) == 0) p[31:25] = 7'd0;
      apply("R2/R5 random", $urandom_range(0, 7) != 0, a, $urandom_range(0, 1) == 1, p, c);
    end
    done = 1'b1;
  end

  initial begin
    void'($urandom(32'd1234));
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule